// File: doc/BRIEF.md
# Cascaded Two-Digit BCD Up/Down Counter

This block counts in decimal, one BCD digit per stage, and chains the stages into a single multi-digit counter. Every stage is clocked by the same clock. A stage advances when the enable reaching it is high. Each stage raises a terminal flag whose meaning follows the count direction: it marks a carry when the digit sits at 9 while counting up, and a borrow when the digit sits at 0 while counting down. That flag, gated by the stage's own enable, becomes the enable of the next higher stage. With the default two digits, the counter cycles through one hundred states.

A run-time truncation mode shortens the cycle. When it is on, the count runs from 00 up to a chosen BCD limit and then returns to 00. Counting down from 00 reloads the limit. An overall terminal output marks the clock edge on which the whole counter wraps, so several of these blocks can be chained the same way.

Top module: `bcd_updown_cascade`

## Requirements
- R1: While rst_n is low, count is forced to all zeros (00), asynchronously.
- R2: On an edge where en is low, count keeps its value.
- R3: With en high, up high and truncation off, count steps by one decimal unit per edge, and 99 goes to 00.
- R4: With en high, up low and truncation off, count drops by one decimal unit per edge, and 00 goes to 99.
- R5: Each 4-bit digit of count (count[3:0] ones, count[7:4] tens) only ever holds 0 to 9.
- R6: With truncation off, the tens digit changes only on an edge where en is high and the ones digit is at its terminal value: 9 when counting up, 0 when counting down.
- R7: With truncation off, term_out is high exactly when en is high and either up is high with count 99, or up is low with count 00.
- R8: With trunc_en high, en high, up high and count equal to trunc_val (two BCD digits), the next count is 00.
- R9: With trunc_en high, en high, up low and count 00, the next count is trunc_val.
- R10: With trunc_en high, term_out is high exactly when en is high and either up is high with count equal to trunc_val, or up is low with count 00.
- R11: While trunc_en is low, trunc_val has no effect on count or term_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all digit stages |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable for the lowest digit |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| trunc_en | input | 1 | Turns on the truncated sequence |
| trunc_val | input | 8 | BCD limit of the truncated sequence (tens in [7:4]) |
| count | output | 8 | Current count as BCD, tens in [7:4], ones in [3:0] |
| term_out | output | 1 | High on the edge where the whole counter wraps |

## Verification
The checker verifies on every cycle that the digits stay in range and that the count holds when disabled. It also checks the one-step decimal change in each direction, that the tens digit holds unless the ones digit carries or borrows, the full-mode terminal flag, and both truncation wrap moves. Only the bench scenarios show complete sequences. These include the run past 99 and back through 00, enable toggling while the tens digit is crossing, limits of 00 and 23, and a changing trunc_val with the mode off that must have no effect.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

   localparam int DIGIT_W = 4;
   localparam int DIGIT_MAX = 9;

   typedef logic [DIGIT_W-1:0] bcd_digit_t;

   // next value of one decade digit, wrapping in either direction
   function automatic bcd_digit_t digit_next(input bcd_digit_t d, input logic dir_up);
      bcd_digit_t r;
      if (dir_up) r = (d >= bcd_digit_t'(DIGIT_MAX)) ? '0 : d + bcd_digit_t'(1);
      else        r = (d == '0) ? bcd_digit_t'(DIGIT_MAX) : d - bcd_digit_t'(1);
      return r;
   endfunction

   // direction-aware terminal flag of one digit
   function automatic logic digit_terminal(input bcd_digit_t d, input logic dir_up);
      return dir_up ? (d == bcd_digit_t'(DIGIT_MAX)) : (d == '0);
   endfunction

endpackage

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
   import bcd_cnt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       dir_up,
   input  logic       load,
   input  bcd_digit_t load_val,
   output bcd_digit_t q,
   output logic       term
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= load_val;
      else if (step)  q <= digit_next(q, dir_up);
   end

   assign term = digit_terminal(q, dir_up);

endmodule

// File: rtl/bcd_trunc_ctrl.sv
module bcd_trunc_ctrl #(
   parameter int NUM_DIGITS = 2
) (
   input  logic                                    en,
   input  logic                                    dir_up,
   input  logic                                    trunc_en,
   input  logic [NUM_DIGITS*bcd_cnt_pkg::DIGIT_W-1:0] cur,
   input  logic [NUM_DIGITS*bcd_cnt_pkg::DIGIT_W-1:0] limit,
   output logic                                    load,
   output logic [NUM_DIGITS*bcd_cnt_pkg::DIGIT_W-1:0] load_val,
   output logic                                    hit
);

   logic at_top, at_bottom;

   always_comb begin
      at_top    = (cur == limit);
      at_bottom = (cur == '0);
      hit       = trunc_en & (dir_up ? at_top : at_bottom);
      load      = en & hit;
      load_val  = dir_up ? '0 : limit;
   end

endmodule

// File: rtl/bcd_updown_cascade.sv
module bcd_updown_cascade #(
   parameter int NUM_DIGITS  = 2,
   parameter bit ALLOW_TRUNC = 1'b1
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       en,
   input  logic                                       up,
   input  logic                                       trunc_en,
   input  logic [NUM_DIGITS*bcd_cnt_pkg::DIGIT_W-1:0] trunc_val,
   output logic [NUM_DIGITS*bcd_cnt_pkg::DIGIT_W-1:0] count,
   output logic                                       term_out
);
   import bcd_cnt_pkg::*;

   localparam int CW = NUM_DIGITS * DIGIT_W;

   initial begin
      assert (NUM_DIGITS >= 1 && NUM_DIGITS <= 8)
         else $fatal(1, "bcd_updown_cascade: NUM_DIGITS out of range");
   end

   logic [NUM_DIGITS:0]   step_chain;
   logic [NUM_DIGITS-1:0] digit_term;
   logic                  wrap_load;
   logic                  wrap_hit;
   logic [CW-1:0]         wrap_val;

   assign step_chain[0] = en;

   generate
      for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
         bcd_digit_stage u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (step_chain[i]),
            .dir_up   (up),
            .load     (wrap_load),
            .load_val (wrap_val[i*DIGIT_W +: DIGIT_W]),
            .q        (count[i*DIGIT_W +: DIGIT_W]),
            .term     (digit_term[i])
         );
         // enable of the next stage: own enable gated by own terminal flag
         assign step_chain[i+1] = step_chain[i] & digit_term[i];
      end

      if (ALLOW_TRUNC) begin : g_trunc
         bcd_trunc_ctrl #(.NUM_DIGITS(NUM_DIGITS)) u_trunc (
            .en       (en),
            .dir_up   (up),
            .trunc_en (trunc_en),
            .cur      (count),
            .limit    (trunc_val),
            .load     (wrap_load),
            .load_val (wrap_val),
            .hit      (wrap_hit)
         );
         assign term_out = trunc_en ? (en & wrap_hit) : step_chain[NUM_DIGITS];
      end else begin : g_full
         assign wrap_load = 1'b0;
         assign wrap_val  = '0;
         assign wrap_hit  = 1'b0;
         assign term_out  = step_chain[NUM_DIGITS];
      end
   endgenerate

endmodule

// File: rtl/bcd_cascade_chk.sv
module bcd_cascade_chk #(
   parameter int NUM_DIGITS  = 2,
   parameter bit ALLOW_TRUNC = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  en,
   input logic                  up,
   input logic                  trunc_en,
   input logic [NUM_DIGITS*4-1:0] trunc_val,
   input logic [NUM_DIGITS*4-1:0] count,
   input logic                  term_out
);
   localparam int CW = NUM_DIGITS * 4;

   function automatic int unsigned modulus();
      int unsigned m = 1;
      for (int k = 0; k < NUM_DIGITS; k++) m = m * 10;
      return m;
   endfunction

   function automatic int unsigned to_int(input logic [CW-1:0] v);
      int unsigned r = 0;
      for (int k = NUM_DIGITS - 1; k >= 0; k--) r = r * 10 + int'(v[k*4 +: 4]);
      return r;
   endfunction

   logic tmode;
   assign tmode = trunc_en & ALLOW_TRUNC;

   generate
      for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_rng
         a_r5_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
            count[i*4 +: 4] <= 4'd9);
      end
      if (NUM_DIGITS >= 2) begin : g_up
         a_r6_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!tmode && !(en && (up ? count[3:0] == 4'd9 : count[3:0] == 4'd0)))
            |=> $stable(count[CW-1:4]));
      end
   endgenerate

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(count));

   a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en && up && !tmode) |=> to_int(count) == (to_int($past(count)) + 1) % modulus());

   a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !up && !tmode) |=>
         to_int(count) == (to_int($past(count)) + modulus() - 1) % modulus());

   a_r7_full_term: assert property (@(posedge clk) disable iff (!rst_n)
      !tmode |-> term_out == (en && (up ? to_int(count) == modulus() - 1 : count == '0)));

   a_r8_trunc_top: assert property (@(posedge clk) disable iff (!rst_n)
      (en && up && tmode && count == trunc_val) |=> count == '0);

   a_r9_trunc_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !up && tmode && count == '0) |=> count == $past(trunc_val));

endmodule

bind bcd_updown_cascade bcd_cascade_chk #(
   .NUM_DIGITS  (NUM_DIGITS),
   .ALLOW_TRUNC (ALLOW_TRUNC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .up        (up),
   .trunc_en  (trunc_en),
   .trunc_val (trunc_val),
   .count     (count),
   .term_out  (term_out)
);

// File: tb/tb_bcd_updown_cascade.sv
`timescale 1ns/1ps
module tb_bcd_updown_cascade;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       up = 1'b1;
   logic       trunc_en = 1'b0;
   logic [7:0] trunc_val = 8'h00;
   logic [7:0] count;
   logic       term_out;

   int vectors = 0;
   int miscompares = 0;
   int model = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bcd_updown_cascade dut (
      .clk(clk), .rst_n(rst_n), .en(en), .up(up),
      .trunc_en(trunc_en), .trunc_val(trunc_val),
      .count(count), .term_out(term_out)
   );

   function automatic logic [7:0] to_bcd(input int x);
      return {4'(x / 10), 4'(x % 10)};
   endfunction

   function automatic int from_bcd(input logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: drive at negedge, check terminal flag, advance model, check count
   task automatic step(input string tag, input bit e, input bit u, input bit te, input int lim);
      int exp_term;
      en = e; up = u; trunc_en = te; trunc_val = to_bcd(lim);
      #1;
      if (te) exp_term = (e && ((u && model == lim) || (!u && model == 0))) ? 1 : 0;
      else    exp_term = (e && ((u && model == 99) || (!u && model == 0))) ? 1 : 0;
      check({tag, " term_out"}, int'(term_out), exp_term);
      if (e) begin
         if (te && u && model == lim)      model = 0;
         else if (te && !u && model == 0)  model = lim;
         else if (u)                       model = (model + 1) % 100;
         else                              model = (model + 99) % 100;
      end
      @(posedge clk);
      @(negedge clk);
      check({tag, " count"}, from_bcd(count), model);
      check("R5 digit range", (count[3:0] <= 4'd9 && count[7:4] <= 4'd9) ? 1 : 0, 1);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset count", int'(count), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 count after release", from_bcd(count), 0);

      for (int k = 0; k < 4; k++) step("R2", 1'b0, 1'b1, 1'b0, 0);
      for (int k = 0; k < 125; k++) step("R3/R7", 1'b1, 1'b1, 1'b0, 0);
      // toggled enable around tens crossings
      for (int k = 0; k < 60; k++) step("R6/R2", (k % 3) != 1, 1'b1, 1'b0, 0);
      for (int k = 0; k < 4; k++) step("R2 hold", 1'b0, 1'b0, 1'b0, 0);
      for (int k = 0; k < 130; k++) step("R4/R7", 1'b1, 1'b0, 1'b0, 0);
      for (int k = 0; k < 40; k++) step("R6 down", (k % 4) != 2, 1'b0, 1'b0, 0);
      // get to 00, then trunc_val changes with the mode off
      while (model != 0) step("R4 to zero", 1'b1, 1'b0, 1'b0, 0);
      for (int k = 0; k < 30; k++) step("R11", 1'b1, 1'b1, 1'b0, (k * 7) % 100);
      for (int k = 0; k < 10; k++) step("R11 down", 1'b1, 1'b0, 1'b0, 5);
      while (model != 0) step("R4 to zero", 1'b1, 1'b0, 1'b0, 0);
      for (int k = 0; k < 60; k++) step("R8/R10", 1'b1, 1'b1, 1'b1, 23);
      for (int k = 0; k < 60; k++) step("R9/R10", 1'b1, 1'b0, 1'b1, 23);
      for (int k = 0; k < 20; k++) step("R8/R10 mixed", (k % 2) == 0, 1'b1, 1'b1, 23);
      while (model != 0) step("R8 to zero", 1'b1, 1'b1, 1'b1, 23);
      for (int k = 0; k < 6; k++) step("R8 limit 00", 1'b1, 1'b1, 1'b1, 0);
      for (int k = 0; k < 6; k++) step("R9 limit 00", 1'b1, 1'b0, 1'b1, 0);
      for (int k = 0; k < 3; k++) step("R9 limit 99", 1'b1, 1'b0, 1'b1, 99);
      for (int k = 0; k < 3; k++) step("R8 limit 99", 1'b1, 1'b1, 1'b1, 99);

      rst_n = 1'b0;
      #1;
      model = 0;
      check("R1 async reset", int'(count), 0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule